// File: doc/BRIEF.md
# ADPCM Nibble Decoder with Loop Snapshot

The block turns a stream of 4-bit adaptive differential codes into signed 16-bit samples. Each code adds or subtracts a difference to a running sample value. The difference is built from a step size chosen by a running step index, and each code also moves that index. Before decoding starts, a header load sets the starting sample value and step index.

For looping sounds the block keeps a saved copy of the decoder state. The caller marks the first code at the loop-start position, and the state in force just before that code is decoded is saved. When playback later wraps back to the loop start, a wrap strobe puts the saved state back into the decoder. The same codes then decode to the same samples again, and the header does not have to be read a second time. Fetching the codes from memory, timing the playback and scaling the output are done elsewhere.

Top module: `adpcm_loop_decoder`

## Requirements
- R1: After reset, `sample_out` is 0 and `index_out` is 0, and the saved loop state is sample 0 with index 0.
- R2: When `hdr_load` is high, the next cycle shows `sample_out` equal to `hdr_sample` and `index_out` equal to min(`hdr_index`, 88). The saved loop state takes the same values. `hdr_load` wins over every other strobe in that cycle.
- R3: The step size for index i is set as follows: step(0) is 7. For i from 1 to 87, step(i) is the larger of step(i-1)+1 and floor(step(i-1)*11/10). step(88) is 32767.
- R4: A code taken with `nib_valid` (and neither `hdr_load` nor `loop_wrap`) changes the sample on the next cycle by a difference d. With s = step(index), d = s>>3 + (code bit0 ? s>>2 : 0) + (code bit1 ? s>>1 : 0) + (code bit2 ? s : 0). Code bit3 set means the sample goes down by d; bit3 clear means it goes up by d.
- R5: The updated sample saturates to the range -32768..32767.
- R6: The low three bits of the code move the index. Values 0 to 3 subtract 1, and values 4, 5, 6 and 7 add 2, 4, 6 and 8. The result is clamped to 0..88, so `index_out` never leaves that range.
- R7: A code taken with `loop_mark` high saves the sample and index that were in force before that code, and the code is still decoded.
- R8: When `loop_wrap` is high and `hdr_load` is low, the next cycle shows the saved sample and index on the outputs. A code offered in that same cycle is dropped.
- R9: In a cycle with none of `hdr_load`, `loop_wrap` or `nib_valid`, both outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hdr_load | input | 1 | Load the starting state from the header |
| hdr_sample | input | 16 | Header starting sample, two's complement |
| hdr_index | input | 7 | Header starting step index |
| nib_valid | input | 1 | A code is present on `nib` |
| nib | input | 4 | ADPCM code |
| loop_mark | input | 1 | This code is the first at the loop start |
| loop_wrap | input | 1 | Playback wrapped; put the saved state back |
| sample_out | output | 16 | Current decoded sample, two's complement |
| index_out | output | 7 | Current step index |

## Verification
Some properties are checked on every cycle. The index stays in range. Both outputs hold when no strobe is present. The sample moves in the direction that code bit3 selects. A header load lands one cycle later. A mark saves the state that was in force before the code, and a wrap puts that saved state back. The exact step table, the difference arithmetic, saturation at both rails, the clamping of an out-of-range header index, and strobe priority are shown only by the bench. It compares each output against its own model of the requirements, using random code streams with loop marks and wraps and a set of directed corner cases.

// File: rtl/adpcm_pkg.sv
package adpcm_pkg;
  localparam int SAMPLE_W = 16;
  localparam int INDEX_W  = 7;
  localparam int CODE_W   = 4;
  localparam int IDX_MAX  = 88;
  localparam int STEPS    = IDX_MAX + 1;

  typedef logic signed [SAMPLE_W-1:0] sample_t;
  typedef logic [INDEX_W-1:0]         index_t;

  typedef struct packed {
    sample_t smp;
    index_t  idx;
  } dec_state_t;

  // Step size for a given index: grows by about ten percent per entry,
  // always by at least one, and ends at full scale.
  function automatic logic [SAMPLE_W-1:0] step_at(input int i);
    int s;
    int t;
    s = 7;
    if (i >= IDX_MAX) return 16'h7fff;
    for (int k = 1; k <= i; k++) begin
      t = (s * 11) / 10;
      s = (t > s) ? t : s + 1;
    end
    return s[SAMPLE_W-1:0];
  endfunction
endpackage

// File: rtl/adpcm_step_rom.sv
module adpcm_step_rom
  import adpcm_pkg::*;
#(
  parameter int ENTRIES = STEPS
) (
  input  index_t              addr,
  output logic [SAMPLE_W-1:0] step
);
  logic [SAMPLE_W-1:0] tab [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_tab
    assign tab[g] = step_at(g);
  end

  always_comb begin
    if (int'(addr) < ENTRIES) step = tab[addr];
    else                      step = tab[ENTRIES-1];
  end
endmodule

// File: rtl/adpcm_nibble_step.sv
module adpcm_nibble_step
  import adpcm_pkg::*;
(
  input  sample_t             cur_smp,
  input  index_t              cur_idx,
  input  logic [CODE_W-1:0]   code,
  input  logic [SAMPLE_W-1:0] step,
  output sample_t             nxt_smp,
  output index_t              nxt_idx
);
  localparam int DW = SAMPLE_W + 1;
  localparam int SW = SAMPLE_W + 2;
  localparam int IW = INDEX_W + 2;
  localparam logic signed [SW-1:0] S_HI = SW'((1 << (SAMPLE_W-1)) - 1);
  localparam logic signed [SW-1:0] S_LO = -SW'(1 << (SAMPLE_W-1));

  logic [DW-1:0]        diff;
  logic signed [SW-1:0] sum;
  logic signed [IW-1:0] adj;
  logic signed [IW-1:0] isum;

  always_comb begin
    diff = DW'(step >> 3);
    if (code[0]) diff = diff + DW'(step >> 2);
    if (code[1]) diff = diff + DW'(step >> 1);
    if (code[2]) diff = diff + DW'(step);
    if (code[3]) sum = SW'(cur_smp) - SW'(diff);
    else         sum = SW'(cur_smp) + SW'(diff);
    if (sum > S_HI)      nxt_smp = sample_t'(S_HI);
    else if (sum < S_LO) nxt_smp = sample_t'(S_LO);
    else                 nxt_smp = sample_t'(sum);
  end

  always_comb begin
    if (code[2]) adj = IW'({code[1:0], 1'b0}) + IW'(2);
    else         adj = -IW'(1);
    isum = $signed({2'b00, cur_idx}) + adj;
    if (isum < 0)              nxt_idx = '0;
    else if (isum > IW'(IDX_MAX)) nxt_idx = index_t'(IDX_MAX);
    else                       nxt_idx = index_t'(isum);
  end
endmodule

// File: rtl/adpcm_loop_decoder.sv
module adpcm_loop_decoder
  import adpcm_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                hdr_load,
  input  logic [SAMPLE_W-1:0] hdr_sample,
  input  logic [INDEX_W-1:0]  hdr_index,
  input  logic                nib_valid,
  input  logic [CODE_W-1:0]   nib,
  input  logic                loop_mark,
  input  logic                loop_wrap,
  output logic [SAMPLE_W-1:0] sample_out,
  output logic [INDEX_W-1:0]  index_out
);
  dec_state_t          cur, snap, nxt, hdr;
  logic [SAMPLE_W-1:0] step;

  assign hdr.smp = sample_t'(hdr_sample);
  assign hdr.idx = (int'(hdr_index) > IDX_MAX) ? index_t'(IDX_MAX) : hdr_index;

  adpcm_step_rom #(.ENTRIES(STEPS)) u_rom (
    .addr (cur.idx),
    .step (step)
  );

  adpcm_nibble_step u_step (
    .cur_smp (cur.smp),
    .cur_idx (cur.idx),
    .code    (nib),
    .step    (step),
    .nxt_smp (nxt.smp),
    .nxt_idx (nxt.idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur  <= '0;
      snap <= '0;
    end else if (hdr_load) begin
      cur  <= hdr;
      snap <= hdr;
    end else if (loop_wrap) begin
      cur  <= snap;
    end else if (nib_valid) begin
      if (loop_mark) snap <= cur;
      cur <= nxt;
    end
  end

  assign sample_out = cur.smp;
  assign index_out  = cur.idx;
endmodule

// File: rtl/adpcm_loop_decoder_chk.sv
module adpcm_loop_decoder_chk
  import adpcm_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                hdr_load,
  input logic [SAMPLE_W-1:0] hdr_sample,
  input logic                nib_valid,
  input logic [CODE_W-1:0]   nib,
  input logic                loop_mark,
  input logic                loop_wrap,
  input logic [SAMPLE_W-1:0] sample_out,
  input logic [INDEX_W-1:0]  index_out,
  input dec_state_t          snap
);
  logic take;
  assign take = nib_valid && !hdr_load && !loop_wrap;

  a_r6_index_range: assert property (@(posedge clk) disable iff (rst)
    int'(index_out) <= IDX_MAX);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!hdr_load && !loop_wrap && !nib_valid) |=> ($stable(sample_out) && $stable(index_out)));

  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    hdr_load |=> (sample_out == $past(hdr_sample)));

  a_r8_restore: assert property (@(posedge clk) disable iff (rst)
    (loop_wrap && !hdr_load) |=> (sample_out == $past(snap.smp) && index_out == $past(snap.idx)));

  a_r7_snapshot: assert property (@(posedge clk) disable iff (rst)
    (take && loop_mark) |=> (snap.smp == $past(sample_out) && snap.idx == $past(index_out)));

  a_r4_rise: assert property (@(posedge clk) disable iff (rst)
    (take && !nib[3]) |=> ($signed(sample_out) >= $signed($past(sample_out))));

  a_r4_fall: assert property (@(posedge clk) disable iff (rst)
    (take && nib[3]) |=> ($signed(sample_out) <= $signed($past(sample_out))));
endmodule

bind adpcm_loop_decoder adpcm_loop_decoder_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .hdr_load   (hdr_load),
  .hdr_sample (hdr_sample),
  .nib_valid  (nib_valid),
  .nib        (nib),
  .loop_mark  (loop_mark),
  .loop_wrap  (loop_wrap),
  .sample_out (sample_out),
  .index_out  (index_out),
  .snap       (snap)
);

// File: tb/sim_adpcm_loop_decoder.sv
`timescale 1ns/1ps
module sim_adpcm_loop_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hdr_load = 1'b0;
  logic [15:0] hdr_sample = '0;
  logic [6:0]  hdr_index = '0;
  logic        nib_valid = 1'b0;
  logic [3:0]  nib = '0;
  logic        loop_mark = 1'b0;
  logic        loop_wrap = 1'b0;
  logic [15:0] sample_out;
  logic [6:0]  index_out;

  int checks = 0;
  int errors = 0;
  int m_s = 0, m_i = 0, ms_s = 0, ms_i = 0;
  int seed = 0;

  always #2.5 clk = ~clk;

  adpcm_loop_decoder u0 (.*);

  function automatic int m_step(input int i);
    int s = 7;
    int t;
    if (i >= 88) return 32767;
    for (int k = 1; k <= i; k++) begin
      t = (s * 11) / 10;
      if (t < s + 1) t = s + 1;
      s = t;
    end
    return s;
  endfunction

  function automatic int m_next_s(input int s, input int i, input logic [3:0] n);
    int st = m_step(i);
    int d = st >> 3;
    int r;
    if (n[0]) d += st >> 2;
    if (n[1]) d += st >> 1;
    if (n[2]) d += st;
    r = n[3] ? s - d : s + d;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  function automatic int m_next_i(input int i, input logic [3:0] n);
    int r;
    case (n[2:0])
      3'd4: r = i + 2;
      3'd5: r = i + 4;
      3'd6: r = i + 6;
      3'd7: r = i + 8;
      default: r = i - 1;
    endcase
    if (r < 0) r = 0;
    if (r > 88) r = 88;
    return r;
  endfunction

  task automatic check(input string tag);
    checks++;
    if ($signed(sample_out) != m_s || int'(index_out) != m_i) begin
      errors++;
      $display("FAIL %s: sample=%0d index=%0d expected sample=%0d index=%0d",
               tag, $signed(sample_out), index_out, m_s, m_i);
    end
  endtask

  // One clock: drive after a falling edge, update the model at the rising
  // edge, compare 1 ns later.
  task automatic step1(input logic ld, input int hs, input int hi, input logic nv,
                       input logic [3:0] n, input logic mk, input logic wr, input string tag);
    @(negedge clk);
    hdr_load = ld; hdr_sample = 16'(hs); hdr_index = 7'(hi);
    nib_valid = nv; nib = n; loop_mark = mk; loop_wrap = wr;
    @(posedge clk);
    if (ld) begin
      m_s = hs; m_i = (hi > 88) ? 88 : hi; ms_s = m_s; ms_i = m_i;
    end else if (wr) begin
      m_s = ms_s; m_i = ms_i;
    end else if (nv) begin
      if (mk) begin ms_s = m_s; ms_i = m_i; end
      begin
        int t = m_next_s(m_s, m_i, n);
        m_i = m_next_i(m_i, n);
        m_s = t;
      end
    end
    #1;
    check(tag);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    seed = $urandom(32'h5a17);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1; check("R1");
    // R1: wrap straight after reset restores the zero state
    step1(0, 0, 0, 1, 4'h7, 0, 0, "R4");
    step1(0, 0, 0, 0, 4'h0, 0, 1, "R1");
    // R3: step(k) probes with code 7 -> d = s/8+s/4+s/2+s
    for (int k = 0; k <= 88; k += 11) begin
      step1(1, 0, k, 0, 0, 0, 0, "R2");
      step1(0, 0, 0, 1, 4'h7, 0, 0, "R3");
    end
    step1(1, 0, 88, 0, 0, 0, 0, "R2");
    step1(0, 0, 0, 1, 4'h0, 0, 0, "R3");
    // R5: saturation at both rails
    step1(1, 32000, 88, 0, 0, 0, 0, "R2");
    step1(0, 0, 0, 1, 4'h7, 0, 0, "R5");
    step1(1, -32000, 88, 0, 0, 0, 0, "R2");
    step1(0, 0, 0, 1, 4'hf, 0, 0, "R5");
    // R6: index clamps at 0 and 88; header index above range clamps
    step1(1, 100, 0, 0, 0, 0, 0, "R2");
    step1(0, 0, 0, 1, 4'h3, 0, 0, "R6");
    step1(1, 100, 120, 0, 0, 0, 0, "R2");
    step1(0, 0, 0, 1, 4'h6, 0, 0, "R6");
    // R2: load wins over a code and a wrap
    step1(1, -5, 10, 1, 4'h7, 1, 1, "R2");
    // R7/R8: mark, decode more, wrap, re-decode the same codes
    step1(0, 0, 0, 1, 4'h5, 0, 0, "R4");
    step1(0, 0, 0, 1, 4'h2, 1, 0, "R7");
    step1(0, 0, 0, 1, 4'hc, 0, 0, "R7");
    step1(0, 0, 0, 1, 4'h7, 0, 1, "R8");
    step1(0, 0, 0, 1, 4'h2, 0, 0, "R8");
    step1(0, 0, 0, 0, 4'h9, 0, 0, "R9");
    // random streams
    for (int c = 0; c < 4000; c++) begin
      int r = $urandom % 100;
      logic [3:0] n = 4'($urandom);
      if (r < 3)       step1(1, int'($signed(16'($urandom))), $urandom % 128, 1, n, 0, 0, "R2");
      else if (r < 8)  step1(0, 0, 0, 1, n, 0, 1, "R8");
      else if (r < 12) step1(0, 0, 0, 1, n, 1, 0, "R7");
      else if (r < 20) step1(0, 0, 0, 0, n, 1, 0, "R9");
      else             step1(0, 0, 0, 1, n, 0, 0, "R4");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule